// File: doc/BRIEF.md
# Legacy Paravirtual Device Register Decoder

This block is the register file of a legacy paravirtual function seen through one byte-addressed window. The driver uses it to read what the device offers, record what it accepts, select a queue and give that queue a ring page frame, ring doorbells, write the device status byte, and fetch and acknowledge the interrupt cause. Each register access turns into a one-cycle event pulse: a queue brought up or torn down, a doorbell for one queue index, or a device reset. The back end, which does the queue processing, consumes these pulses.

The interrupt status register is cleared by reading it, and the legacy interrupt line is high while the register holds any nonzero value. When message-signalled interrupts are enabled, a config vector and a per-queue vector are placed at the start of the device-specific region, and the small device config window moves up four bytes to make room for them. The vectors are used only to hold the vector numbers; this block sends no messages.

Top module: `pvdev_regs`

## Requirements
- R1: A read of the ISR at offset 19 returns its value with the same latency as any other read, and clears the ISR to zero. An interrupt event in the same cycle as that read is kept: it is set after the clear.
- R2: A write to the queue selector at offset 14 whose low 16 bits are greater than or equal to NUM_QUEUES is dropped. The selector keeps its previous value. Reads of offset 14 return the selector.
- R3: A write to the doorbell at offset 16 whose low 16 bits are below NUM_QUEUES pulses `notify` for one cycle, with `notify_idx` equal to that value. Values at or above NUM_QUEUES produce no pulse.
- R4: A nonzero write to the page-frame register at offset 8 stores the 32-bit frame for the selected queue and pulses `q_activate`. A zero write stores zero, resets that queue's vector to 0xFFFF and pulses `q_deactivate`. In both cases `q_index` is the selected queue.
- R5: The 8-bit status register at offset 18 reads back the value last written and drives `dev_status`. Writing zero to it pulses `dev_reset` for one cycle.
- R6: `irq_vq` sets ISR bit 0 and `irq_cfg` sets ISR bit 1. `irq_line` is high exactly while the ISR is nonzero.
- R7: With `msix_en` high, offset 20 is the 16-bit config vector, offset 22 is the 16-bit vector of the selected queue, and config byte i is at offset 24+i. With `msix_en` low, config byte i is at offset 20+i and the vectors cannot be reached.
- R8: Offset 0 reads `host_feat`. Offset 4 is a 32-bit guest feature word that reads back and drives `guest_feat`. Offset 12 reads QUEUE_SIZE as a 16-bit value.
- R9: Reads of undefined offsets return zero and writes to them are ignored. Writes to the read-only registers at offsets 0, 12 and 19 have no effect.
- R10: After reset, the config vector and every queue vector read 0xFFFF, the "no vector" code.
- R11: `rdata` and `rd_valid` are valid in the cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset in the window |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data, zero-extended |
| rd_valid | output | 1 | Read data valid |
| host_feat | input | 32 | Feature word offered by the device |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| irq_vq | input | 1 | Queue interrupt event |
| irq_cfg | input | 1 | Config-change interrupt event |
| guest_feat | output | 32 | Feature word accepted by the driver |
| dev_status | output | 8 | Device status byte |
| q_activate | output | 1 | Queue bring-up pulse |
| q_deactivate | output | 1 | Queue teardown pulse |
| q_index | output | QIDX_W | Queue for the bring-up or teardown pulse |
| notify | output | 1 | Doorbell pulse |
| notify_idx | output | 16 | Doorbell queue index |
| dev_reset | output | 1 | Device reset pulse |
| irq_line | output | 1 | Legacy interrupt line |

## Verification
A selector that takes an out-of-range value shows up at the ports on the very next access: the read of offset 14 returns the wrong value, and page-frame or vector accesses reach the wrong queue, so their readback and `q_index` are wrong. An ISR that does not clear keeps `irq_line` high in the cycle after the read, and a second read returns nonzero. A wrong window base for a given `msix_en` makes the vector and config readbacks swap or read as zero, and does so at once after `msix_en` is toggled.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_HOSTF, RG_GUESTF, RG_PFN, RG_QSIZE, RG_QSEL,
    RG_NOTIFY, RG_STATUS, RG_ISR, RG_CVEC, RG_QVEC, RG_CFG
  } reg_e;

  localparam int unsigned OFF_HOSTF  = 0;
  localparam int unsigned OFF_GUESTF = 4;
  localparam int unsigned OFF_PFN    = 8;
  localparam int unsigned OFF_QSIZE  = 12;
  localparam int unsigned OFF_QSEL   = 14;
  localparam int unsigned OFF_NOTIFY = 16;
  localparam int unsigned OFF_STATUS = 18;
  localparam int unsigned OFF_ISR    = 19;
  localparam int unsigned OFF_SPEC   = 20;
  localparam int unsigned OFF_CVEC   = 20;
  localparam int unsigned OFF_QVEC   = 22;
  localparam int unsigned VEC_BYTES  = 4;
  localparam logic [15:0] NO_VECTOR  = 16'hFFFF;

  // Start of the device config window for the current interrupt mode.
  function automatic int unsigned cfg_base(input logic msix);
    return msix ? OFF_SPEC + VEC_BYTES : OFF_SPEC;
  endfunction

  // A 16-bit queue index is valid only below the queue count.
  function automatic logic idx_ok(input logic [15:0] v, input int unsigned n);
    return 32'(v) < n;
  endfunction

endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode
  import pvdev_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CFG_BYTES = 8,
  localparam int CIDX_W   = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              msix,
  output reg_e              rsel,
  output logic [CIDX_W-1:0] cfg_idx
);
  int unsigned a;
  int unsigned base;

  always_comb begin
    a       = 32'(addr);
    base    = cfg_base(msix);
    rsel    = RG_NONE;
    cfg_idx = '0;
    if (a == OFF_HOSTF)       rsel = RG_HOSTF;
    else if (a == OFF_GUESTF) rsel = RG_GUESTF;
    else if (a == OFF_PFN)    rsel = RG_PFN;
    else if (a == OFF_QSIZE)  rsel = RG_QSIZE;
    else if (a == OFF_QSEL)   rsel = RG_QSEL;
    else if (a == OFF_NOTIFY) rsel = RG_NOTIFY;
    else if (a == OFF_STATUS) rsel = RG_STATUS;
    else if (a == OFF_ISR)    rsel = RG_ISR;
    else if (msix && a == OFF_CVEC) rsel = RG_CVEC;
    else if (msix && a == OFF_QVEC) rsel = RG_QVEC;
    else if (a >= base && a < base + CFG_BYTES) begin
      rsel    = RG_CFG;
      cfg_idx = CIDX_W'(a - base);
    end
  end
endmodule

// File: rtl/pvdev_queue_file.sv
module pvdev_queue_file
  import pvdev_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  localparam int QIDX_W    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QIDX_W-1:0] sel,
  input  logic              pfn_we,
  input  logic [31:0]       pfn_wd,
  input  logic              vec_we,
  input  logic [15:0]       vec_wd,
  input  logic              vec_clr,
  output logic [31:0]       pfn_rd,
  output logic [15:0]       vec_rd
);
  logic [31:0] pfn_arr [NUM_QUEUES];
  logic [15:0] vec_arr [NUM_QUEUES];

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
    logic hit;
    assign hit = (32'(sel) == q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pfn_arr[q] <= '0;
        vec_arr[q] <= NO_VECTOR;
      end else begin
        if (pfn_we && hit) pfn_arr[q] <= pfn_wd;
        if (vec_clr && hit)     vec_arr[q] <= NO_VECTOR;
        else if (vec_we && hit) vec_arr[q] <= vec_wd;
      end
    end
  end

  always_comb begin
    pfn_rd = '0;
    vec_rd = NO_VECTOR;
    if (32'(sel) < NUM_QUEUES) begin
      pfn_rd = pfn_arr[sel];
      vec_rd = vec_arr[sel];
    end
  end
endmodule

// File: rtl/pvdev_cfg_ram.sv
module pvdev_cfg_ram #(
  parameter int CFG_BYTES = 8,
  localparam int CIDX_W   = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CIDX_W-1:0] idx,
  input  logic [7:0]        wd,
  output logic [7:0]        rd
);
  logic [7:0] mem [CFG_BYTES];

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_b
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     mem[i] <= '0;
      else if (we && 32'(idx) == i)   mem[i] <= wd;
    end
  end

  assign rd = (32'(idx) < CFG_BYTES) ? mem[idx] : 8'h00;
endmodule

// File: rtl/pvdev_regs.sv
module pvdev_regs
  import pvdev_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int QUEUE_SIZE = 256,
  parameter int CFG_BYTES  = 8,
  parameter int ADDR_W     = 6,
  localparam int QIDX_W    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int CIDX_W    = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [31:0]       host_feat,
  input  logic              msix_en,
  input  logic              irq_vq,
  input  logic              irq_cfg,
  output logic [31:0]       guest_feat,
  output logic [7:0]        dev_status,
  output logic              q_activate,
  output logic              q_deactivate,
  output logic [QIDX_W-1:0] q_index,
  output logic              notify,
  output logic [15:0]       notify_idx,
  output logic              dev_reset,
  output logic              irq_line
);
  reg_e              rsel;
  logic [CIDX_W-1:0] cidx;
  logic [QIDX_W-1:0] sel_q;
  logic [1:0]        isr_q;
  logic [15:0]       cvec_q;
  logic [31:0]       pfn_rd;
  logic [15:0]       qvec_rd;
  logic [7:0]        cfg_rd;
  logic [31:0]       rd_mux;

  // Named access events.
  logic ev_pfn, ev_pfn_zero, ev_qsel_ok, ev_notify_ok, ev_status0, ev_isr_rd;
  assign ev_pfn       = wr_en && rsel == RG_PFN;
  assign ev_pfn_zero  = wdata == 32'h0;
  assign ev_qsel_ok   = wr_en && rsel == RG_QSEL && idx_ok(wdata[15:0], NUM_QUEUES);
  assign ev_notify_ok = wr_en && rsel == RG_NOTIFY && idx_ok(wdata[15:0], NUM_QUEUES);
  assign ev_status0   = wr_en && rsel == RG_STATUS && wdata[7:0] == 8'h00;
  assign ev_isr_rd    = rd_en && rsel == RG_ISR;

  pvdev_decode #(.ADDR_W(ADDR_W), .CFG_BYTES(CFG_BYTES)) u_dec (
    .addr(addr), .msix(msix_en), .rsel(rsel), .cfg_idx(cidx)
  );

  pvdev_queue_file #(.NUM_QUEUES(NUM_QUEUES)) u_qf (
    .clk(clk), .rst_n(rst_n), .sel(sel_q),
    .pfn_we(ev_pfn), .pfn_wd(wdata),
    .vec_we(wr_en && rsel == RG_QVEC), .vec_wd(wdata[15:0]),
    .vec_clr(ev_pfn && ev_pfn_zero),
    .pfn_rd(pfn_rd), .vec_rd(qvec_rd)
  );

  pvdev_cfg_ram #(.CFG_BYTES(CFG_BYTES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr_en && rsel == RG_CFG),
    .idx(cidx), .wd(wdata[7:0]), .rd(cfg_rd)
  );

  always_comb begin
    unique case (rsel)
      RG_HOSTF:  rd_mux = host_feat;
      RG_GUESTF: rd_mux = guest_feat;
      RG_PFN:    rd_mux = pfn_rd;
      RG_QSIZE:  rd_mux = 32'(16'(QUEUE_SIZE));
      RG_QSEL:   rd_mux = 32'(sel_q);
      RG_STATUS: rd_mux = 32'(dev_status);
      RG_ISR:    rd_mux = 32'(isr_q);
      RG_CVEC:   rd_mux = 32'(cvec_q);
      RG_QVEC:   rd_mux = 32'(qvec_rd);
      RG_CFG:    rd_mux = 32'(cfg_rd);
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata        <= '0;
      rd_valid     <= 1'b0;
      guest_feat   <= '0;
      dev_status   <= '0;
      sel_q        <= '0;
      cvec_q       <= NO_VECTOR;
      isr_q        <= '0;
      q_activate   <= 1'b0;
      q_deactivate <= 1'b0;
      q_index      <= '0;
      notify       <= 1'b0;
      notify_idx   <= '0;
      dev_reset    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
      if (wr_en && rsel == RG_GUESTF) guest_feat <= wdata;
      if (wr_en && rsel == RG_STATUS) dev_status <= wdata[7:0];
      if (wr_en && rsel == RG_CVEC)   cvec_q     <= wdata[15:0];
      if (ev_qsel_ok)                 sel_q      <= wdata[QIDX_W-1:0];
      // New events win over the read-clear of the same cycle.
      isr_q        <= (ev_isr_rd ? 2'b00 : isr_q) | {irq_cfg, irq_vq};
      q_activate   <= ev_pfn && !ev_pfn_zero;
      q_deactivate <= ev_pfn && ev_pfn_zero;
      if (ev_pfn) q_index <= sel_q;
      notify       <= ev_notify_ok;
      if (ev_notify_ok) notify_idx <= wdata[15:0];
      dev_reset    <= ev_status0;
    end
  end

  assign irq_line = isr_q != 2'b00;
endmodule

// File: rtl/pvdev_regs_chk.sv
module pvdev_regs_chk
  import pvdev_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int ADDR_W     = 6,
  parameter int QIDX_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              irq_vq,
  input logic              irq_cfg,
  input logic              irq_line,
  input logic              q_activate,
  input logic              q_deactivate,
  input logic              notify,
  input logic [15:0]       notify_idx,
  input logic              dev_reset,
  input logic              rd_valid,
  input logic [QIDX_W-1:0] sel_q
);
  AST_ISR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == ADDR_W'(OFF_ISR) && !irq_vq && !irq_cfg) |=> !irq_line); // R1
  AST_QSEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_QSEL) && 32'(wdata[15:0]) >= NUM_QUEUES) |=> $stable(sel_q)); // R2
  AST_NOTIFY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> 32'(notify_idx) < NUM_QUEUES); // R3
  AST_ACT_DEACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_activate && q_deactivate)); // R4
  AST_STATUS_ZERO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_STATUS) && wdata[7:0] == 8'h00) |=> dev_reset); // R5
  AST_EVENT_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vq || irq_cfg) |=> irq_line); // R6
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R11
endmodule

bind pvdev_regs pvdev_regs_chk #(
  .NUM_QUEUES(NUM_QUEUES), .ADDR_W(ADDR_W), .QIDX_W(QIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq_vq(irq_vq), .irq_cfg(irq_cfg), .irq_line(irq_line),
  .q_activate(q_activate), .q_deactivate(q_deactivate), .notify(notify),
  .notify_idx(notify_idx), .dev_reset(dev_reset), .rd_valid(rd_valid),
  .sel_q(sel_q)
);

// File: tb/pvdev_regs_bench.sv
module pvdev_regs_bench;
  localparam int NQ = 4;
  localparam int QS = 256;
  localparam int CB = 8;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [31:0] host_feat = 32'hA5A5_0F0F;
  logic        msix_en = 1'b1;
  logic        irq_vq = 1'b0, irq_cfg = 1'b0;
  logic [31:0] guest_feat;
  logic [7:0]  dev_status;
  logic        q_activate, q_deactivate, notify, dev_reset, irq_line;
  logic [1:0]  q_index;
  logic [15:0] notify_idx;

  int checks = 0;
  int errors = 0;

  // Outputs seen right after the last write.
  logic       s_act, s_deact, s_nt, s_rst;
  logic [1:0] s_qi;
  logic [15:0] s_ni;

  always #5 clk = ~clk;

  pvdev_regs #(.NUM_QUEUES(NQ), .QUEUE_SIZE(QS), .CFG_BYTES(CB), .ADDR_W(AW)) u_pvdev_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .host_feat(host_feat),
    .msix_en(msix_en), .irq_vq(irq_vq), .irq_cfg(irq_cfg),
    .guest_feat(guest_feat), .dev_status(dev_status), .q_activate(q_activate),
    .q_deactivate(q_deactivate), .q_index(q_index), .notify(notify),
    .notify_idx(notify_idx), .dev_reset(dev_reset), .irq_line(irq_line)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    s_act = q_activate; s_deact = q_deactivate; s_qi = q_index;
    s_nt = notify; s_ni = notify_idx; s_rst = dev_reset;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    chk("R11 rd_valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic pulse_irq(input logic v, input logic c);
    @(negedge clk);
    irq_vq = v; irq_cfg = c;
    @(negedge clk);
    irq_vq = 1'b0; irq_cfg = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int sel_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset irq_line", 32'(irq_line), 0);
    chk("reset dev_reset", 32'(dev_reset), 0);
    chk("reset notify", 32'(notify), 0);

    // R10 vectors after reset
    rd(20, d); chk("R10 config vector", d, 32'hFFFF);
    for (int q = 0; q < NQ; q++) begin
      wr(14, q); rd(22, d); chk("R10 queue vector", d, 32'hFFFF);
    end

    // R8 feature words and queue size
    rd(0, d); chk("R8 host features", d, 32'hA5A5_0F0F);
    wr(4, 32'h1234_5678); rd(4, d); chk("R8 guest readback", d, 32'h1234_5678);
    chk("R8 guest port", guest_feat, 32'h1234_5678);
    rd(12, d); chk("R8 queue size", d, QS);

    // R9 read-only and undefined offsets
    wr(0, 32'h0); rd(0, d); chk("R9 host write ignored", d, 32'hA5A5_0F0F);
    wr(12, 32'h7); rd(12, d); chk("R9 qsize write ignored", d, QS);
    for (int a = 32; a < 64; a += 4) begin
      wr(a, 32'hDEAD_BEEF); rd(a, d); chk("R9 undefined reads zero", d, 0);
    end
    rd(2, d); chk("R9 offset 2", d, 0);
    rd(13, d); chk("R9 offset 13", d, 0);

    // R2 selector sweep
    sel_exp = NQ - 1;
    for (int v = 0; v < 2 * NQ; v++) begin
      wr(14, v);
      if (v < NQ) sel_exp = v;
      rd(14, d); chk("R2 selector", d, sel_exp);
    end
    wr(14, 32'h0001_0001); rd(14, d); chk("R2 low half used", d, 1);
    wr(14, 32'h0000_FFFF); rd(14, d); chk("R2 large rejected", d, 1);

    // R3 doorbell sweep
    for (int v = 0; v < 2 * NQ; v++) begin
      wr(16, v);
      chk("R3 notify pulse", 32'(s_nt), (v < NQ) ? 1 : 0);
      if (v < NQ) chk("R3 notify index", 32'(s_ni), v);
    end
    wr(16, 32'h0000_0100); chk("R3 0x100 ignored", 32'(s_nt), 0);

    // R4 page frames with vectors
    for (int q = 0; q < NQ; q++) begin
      wr(14, q);
      wr(22, 32'h10 + q);
      wr(8, 32'h8000_1000 + q);
      chk("R4 activate", 32'(s_act), 1);
      chk("R4 no deactivate", 32'(s_deact), 0);
      chk("R4 index", 32'(s_qi), q);
    end
    for (int q = 0; q < NQ; q++) begin
      wr(14, q); rd(8, d); chk("R4 frame readback", d, 32'h8000_1000 + q);
    end
    wr(14, 2); wr(8, 0);
    chk("R4 deactivate", 32'(s_deact), 1);
    chk("R4 no activate", 32'(s_act), 0);
    chk("R4 deact index", 32'(s_qi), 2);
    for (int q = 0; q < NQ; q++) begin
      wr(14, q); rd(22, d);
      chk("R4 vector after teardown", d, (q == 2) ? 32'hFFFF : 32'h10 + q);
      rd(8, d);
      chk("R4 frame after teardown", d, (q == 2) ? 0 : 32'h8000_1000 + q);
    end

    // R5 status
    wr(18, 32'h0F); chk("R5 no reset on nonzero", 32'(s_rst), 0);
    rd(18, d); chk("R5 status readback", d, 32'h0F);
    chk("R5 status port", 32'(dev_status), 32'h0F);
    wr(18, 32'h100); chk("R5 zero low byte resets", 32'(s_rst), 1);
    rd(18, d); chk("R5 status zero", d, 0);
    @(negedge clk); chk("R5 pulse one cycle", 32'(dev_reset), 0);

    // R6 / R1 interrupt status
    chk("R6 line idle", 32'(irq_line), 0);
    pulse_irq(1'b1, 1'b0); chk("R6 line on queue event", 32'(irq_line), 1);
    rd(19, d); chk("R1 isr queue bit", d, 1);
    chk("R1 line cleared", 32'(irq_line), 0);
    rd(19, d); chk("R1 second read zero", d, 0);
    pulse_irq(1'b0, 1'b1); rd(19, d); chk("R6 isr config bit", d, 2);
    pulse_irq(1'b1, 1'b1); rd(19, d); chk("R6 isr both bits", d, 3);
    wr(19, 32'h0); chk("R9 isr write ignored", 32'(irq_line), 0);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(19); irq_vq = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; irq_vq = 1'b0;
    chk("R1 same-cycle read old", rdata, 0);
    chk("R1 same-cycle event kept", 32'(irq_line), 1);
    rd(19, d); chk("R1 kept event readable", d, 1);

    // R7 window placement
    msix_en = 1'b1;
    wr(20, 32'h0003);
    wr(14, 1); wr(22, 32'h0042);
    msix_en = 1'b0;
    for (int i = 0; i < CB; i++) wr(20 + i, 32'h40 + i);
    msix_en = 1'b1;
    rd(20, d); chk("R7 config vector kept", d, 32'h0003);
    rd(22, d); chk("R7 queue vector kept", d, 32'h0042);
    for (int i = 0; i < CB; i++) begin
      rd(24 + i, d); chk("R7 window shifted", d, 32'h40 + i);
    end
    rd(24 + CB, d); chk("R7 past window", d, 0);
    msix_en = 1'b0;
    for (int i = 0; i < CB; i++) begin
      rd(20 + i, d); chk("R7 window unshifted", d, 32'h40 + i);
    end
    rd(20 + CB, d); chk("R7 past window off", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule